// File: doc/BRIEF.md
# Two-Lane Double-Precision Vector Compare Unit

This unit compares two vectors of IEEE 754 double-precision numbers lane by lane and writes a mask per lane. A lane that satisfies the selected predicate (equal, greater-than or greater-or-equal) gets all ones, and any other lane gets zero. The unit also returns a two-bit condition code derived from how many lanes matched. A scalar mode compares only the lowest lane of each operand, in quiet or signaling form, and reports equal, low, high or unordered.

Lanes are evaluated one per cycle after a request is accepted. For each lane the unit presents that lane's invalid-operation flag to an external exception unit, and it samples a trap answer in the same cycle. A trap ends the operation after the current lane. Lanes that were never evaluated stay zero. The final mask, condition code, the OR of all evaluated invalid flags and a trapped indication are shown for one cycle on the result port.

Top module: `vfc_compare`

## Requirements
- R1: While reset is asserted and right after it, `res_valid` and `exc_valid` are 0, `req_ready` is 1 and `res_mask` is all zero.
- R2: Lane i of the operands and of `res_mask` occupies bits [64*i+63 : 64*i]. An evaluated lane that matches gets 64'hFFFF_FFFF_FFFF_FFFF, and any other lane gets zero.
- R3: Predicate code 2'd0 (equal) uses the quiet form. It treats +0 and -0 as equal and is false whenever either operand is a NaN.
- R4: Predicate code 2'd1 matches when the lane of `req_a` is greater than the lane of `req_b`. Code 2'd2 matches when it is greater or equal. Both are built as less-than and less-or-equal with the operands swapped, and both are false for any NaN.
- R5: In vector mode the condition code is 0 when the number of matching lanes equals LANES, 3 when no lane matches, and 1 otherwise.
- R6: With `req_single` set, only lane 0 is evaluated and all other lanes stay zero. The condition code is 0 if lane 0 matches and 3 if it does not.
- R7: With `req_scalar` set, lane 0 of `req_a` is compared with lane 0 of `req_b`. The condition code is 0 for equal, 1 when a < b, 2 when a > b and 3 for unordered. `res_mask` is zero.
- R8: The invalid flag of a comparison is set for a signaling NaN operand (exponent all ones, fraction nonzero, fraction MSB 0). In scalar mode with `req_signaling` set, it is set for any NaN operand instead.
- R9: `exc_trap` high during a lane's `exc_valid` cycle ends the operation after that lane. `res_trapped` is set, and later lanes stay zero.
- R10: `res_invalid` is the OR of the invalid flags of all evaluated lanes.
- R11: Each evaluated lane produces exactly one `exc_valid` cycle. `exc_lane` counts up from 0, and `res_valid` follows one cycle after the last evaluated lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is 1 |
| req_ready | output | 1 | Unit idle and able to take a request |
| req_scalar | input | 1 | Scalar compare of lane 0 |
| req_pred | input | 2 | Vector predicate: 0 equal, 1 greater, 2 greater-or-equal |
| req_single | input | 1 | Vector mode on lane 0 only |
| req_signaling | input | 1 | Scalar signaling form |
| req_a | input | LANES*64 | First operand vector |
| req_b | input | LANES*64 | Second operand vector |
| exc_valid | output | 1 | A lane is being evaluated this cycle |
| exc_lane | output | LIW | Index of the lane being evaluated |
| exc_invalid | output | 1 | Invalid flag of the current lane |
| exc_trap | input | 1 | Trap answer for the current lane |
| res_valid | output | 1 | Result strobe, one cycle |
| res_mask | output | LANES*64 | Per-lane match mask |
| res_cc | output | 2 | Condition code |
| res_invalid | output | 1 | Combined invalid flag |
| res_trapped | output | 1 | Operation ended by a trap |

## Verification
A lane's match and a trap on that same lane happen in one cycle. The mask must keep the trapped lane's result, stop before the next lane, and still derive the condition code from the partial match count. The bench provokes this by returning a trap while lane 0 matches, and again at lane 1. It predicts the mask, the code and the trapped flag from its own lane model. It also starts a new request in the cycle the previous result is shown, which checks that clearing and presenting do not interfere.

// File: rtl/vfc_pkg.sv
package vfc_pkg;
  localparam int DW = 64;
  localparam int EW = 11;
  localparam int FW = 52;

  typedef enum logic [1:0] {
    PRED_EQ = 2'd0,
    PRED_GT = 2'd1,
    PRED_GE = 2'd2
  } pred_e;

  typedef struct packed {
    logic lt;
    logic eq;
    logic unord;
    logic inv;
  } cmp_res_t;
endpackage

// File: rtl/vfc_dcmp.sv
module vfc_dcmp
  import vfc_pkg::*;
(
  input  logic [DW-1:0] x,
  input  logic [DW-1:0] y,
  input  logic          signaling,
  output cmp_res_t      res
);
  logic x_nan, y_nan, x_snan, y_snan, both_zero, mag_lt, mag_gt, lt_raw;

  assign x_nan     = (&x[DW-2:FW]) && (|x[FW-1:0]);
  assign y_nan     = (&y[DW-2:FW]) && (|y[FW-1:0]);
  assign x_snan    = x_nan && !x[FW-1];
  assign y_snan    = y_nan && !y[FW-1];
  assign both_zero = ~|x[DW-2:0] && ~|y[DW-2:0];
  assign mag_lt    = x[DW-2:0] < y[DW-2:0];
  assign mag_gt    = x[DW-2:0] > y[DW-2:0];

  always_comb begin
    if (both_zero)               lt_raw = 1'b0;
    else if (x[DW-1] != y[DW-1]) lt_raw = x[DW-1];
    else if (x[DW-1])            lt_raw = mag_gt;
    else                         lt_raw = mag_lt;
  end

  always_comb begin
    res.unord = x_nan || y_nan;
    res.eq    = !res.unord && ((x == y) || both_zero);
    res.lt    = !res.unord && lt_raw;
    res.inv   = signaling ? res.unord : (x_snan || y_snan);
  end
endmodule

// File: rtl/vfc_ctrl.sv
module vfc_ctrl #(
  parameter int LANES = 2,
  parameter int LIW   = 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           one_lane,
  input  logic           trap,
  output logic           busy,
  output logic [LIW-1:0] lane,
  output logic           finish
);
  logic           busy_q, busy_d;
  logic [LIW-1:0] lane_q, lane_d;
  logic           last;

  assign last   = one_lane || (lane_q == LIW'(LANES - 1));
  assign finish = busy_q && (trap || last);
  assign busy   = busy_q;
  assign lane   = lane_q;

  always_comb begin
    busy_d = busy_q;
    lane_d = lane_q;
    if (start) begin
      busy_d = 1'b1;
      lane_d = '0;
    end else if (finish) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      lane_d = lane_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      lane_q <= '0;
    end else begin
      busy_q <= busy_d;
      lane_q <= lane_d;
    end
  end
endmodule

// File: rtl/vfc_cc.sv
module vfc_cc #(
  parameter int LANES = 2,
  parameter int CW    = 2
) (
  input  logic [CW-1:0] match_cnt,
  input  logic          single,
  output logic [1:0]    cc
);
  always_comb begin
    if (match_cnt == '0)                            cc = 2'd3;
    else if (single || (match_cnt == CW'(LANES)))   cc = 2'd0;
    else                                            cc = 2'd1;
  end
endmodule

// File: rtl/vfc_compare.sv
module vfc_compare
  import vfc_pkg::*;
#(
  parameter int LANES = 2,
  parameter int LIW   = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_scalar,
  input  logic [1:0]          req_pred,
  input  logic                req_single,
  input  logic                req_signaling,
  input  logic [LANES*64-1:0] req_a,
  input  logic [LANES*64-1:0] req_b,
  output logic                exc_valid,
  output logic [LIW-1:0]      exc_lane,
  output logic                exc_invalid,
  input  logic                exc_trap,
  output logic                res_valid,
  output logic [LANES*64-1:0] res_mask,
  output logic [1:0]          res_cc,
  output logic                res_invalid,
  output logic                res_trapped
);
  localparam int VW = LANES * DW;
  localparam int CW = $clog2(LANES + 1);

  logic [VW-1:0]  a_q, b_q, mask_q, mask_d;
  logic           scalar_q, single_q, signal_q;
  logic [1:0]     pred_q;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic           inv_q, inv_d, done_q, trapped_q;
  logic [1:0]     cc_q, vec_cc, scl_cc;
  logic           busy, finish, accept, pred_hit, lane_match;
  logic [LIW-1:0] lane;
  logic [DW-1:0]  cur_a, cur_b;
  cmp_res_t       cmp;

  assign accept = req_valid && !busy;

  vfc_ctrl #(.LANES(LANES), .LIW(LIW)) i_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (accept),
    .one_lane (scalar_q || single_q),
    .trap     (exc_trap),
    .busy     (busy),
    .lane     (lane),
    .finish   (finish)
  );

  assign cur_a = a_q[lane*DW +: DW];
  assign cur_b = b_q[lane*DW +: DW];

  // operands swapped: x = b, y = a, so cmp.lt means a > b
  vfc_dcmp i_dcmp (
    .x         (cur_b),
    .y         (cur_a),
    .signaling (scalar_q && signal_q),
    .res       (cmp)
  );

  always_comb begin
    case (pred_e'(pred_q))
      PRED_GT: pred_hit = cmp.lt;
      PRED_GE: pred_hit = cmp.lt || cmp.eq;
      default: pred_hit = cmp.eq;
    endcase
  end

  assign lane_match = !scalar_q && pred_hit;

  always_comb begin
    if (cmp.unord)   scl_cc = 2'd3;
    else if (cmp.eq) scl_cc = 2'd0;
    else if (cmp.lt) scl_cc = 2'd2;
    else             scl_cc = 2'd1;
  end

  assign cnt_d = cnt_q + CW'(lane_match);
  assign inv_d = inv_q || cmp.inv;

  vfc_cc #(.LANES(LANES), .CW(CW)) i_cc (
    .match_cnt (cnt_d),
    .single    (single_q),
    .cc        (vec_cc)
  );

  for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
    assign mask_d[gi*DW +: DW] =
      accept                                             ? '0 :
      (busy && (lane == LIW'(gi)) && lane_match)         ? {DW{1'b1}} :
                                                           mask_q[gi*DW +: DW];
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      a_q      <= req_a;
      b_q      <= req_b;
      scalar_q <= req_scalar;
      single_q <= req_single;
      signal_q <= req_signaling;
      pred_q   <= req_pred;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q    <= '0;
      cnt_q     <= '0;
      inv_q     <= 1'b0;
      done_q    <= 1'b0;
      cc_q      <= 2'd0;
      trapped_q <= 1'b0;
    end else begin
      mask_q <= mask_d;
      done_q <= finish;
      if (accept) begin
        cnt_q <= '0;
        inv_q <= 1'b0;
      end else if (busy) begin
        cnt_q <= cnt_d;
        inv_q <= inv_d;
      end
      if (finish) begin
        cc_q      <= scalar_q ? scl_cc : vec_cc;
        trapped_q <= exc_trap;
      end
    end
  end

  assign req_ready   = !busy;
  assign exc_valid   = busy;
  assign exc_lane    = lane;
  assign exc_invalid = busy && cmp.inv;
  assign res_valid   = done_q;
  assign res_mask    = mask_q;
  assign res_cc      = cc_q;
  assign res_invalid = inv_q;
  assign res_trapped = trapped_q;
endmodule

// File: rtl/vfc_compare_chk.sv
module vfc_compare_chk #(
  parameter int LANES = 2,
  parameter int LIW   = 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                exc_valid,
  input logic [LIW-1:0]      exc_lane,
  input logic                exc_trap,
  input logic                res_valid,
  input logic [LANES*64-1:0] res_mask,
  input logic [1:0]          res_cc
);
  logic lanes_ok;

  always_comb begin
    lanes_ok = 1'b1;
    for (int i = 0; i < LANES; i++) begin
      if (!(&res_mask[i*64 +: 64]) && (|res_mask[i*64 +: 64])) lanes_ok = 1'b0;
    end
  end

  // R11
  lane_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid && (exc_lane != '0) |->
      $past(exc_valid) && !$past(exc_trap) && (exc_lane == $past(exc_lane) + 1'b1));

  // R9
  trap_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid && exc_trap |=> !exc_valid && res_valid);

  // R11
  done_after_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(exc_valid) && !exc_valid);

  // R2
  lane_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> lanes_ok);

  // R5
  none_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && (res_cc == 2'd3) |-> (res_mask == '0));

  // R7
  high_scalar_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && (res_cc == 2'd2) |-> (res_mask == '0));
endmodule

bind vfc_compare vfc_compare_chk #(.LANES(LANES), .LIW(LIW)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .exc_valid (exc_valid),
  .exc_lane  (exc_lane),
  .exc_trap  (exc_trap),
  .res_valid (res_valid),
  .res_mask  (res_mask),
  .res_cc    (res_cc)
);

// File: tb/test_vfc_compare.sv
`timescale 1ns/1ps
module test_vfc_compare;
  localparam logic [63:0] ONE  = 64'h3FF0_0000_0000_0000;
  localparam logic [63:0] TWO  = 64'h4000_0000_0000_0000;
  localparam logic [63:0] NEG1 = 64'hBFF0_0000_0000_0000;
  localparam logic [63:0] PZ   = 64'h0000_0000_0000_0000;
  localparam logic [63:0] NZ   = 64'h8000_0000_0000_0000;
  localparam logic [63:0] QNAN = 64'h7FF8_0000_0000_0000;
  localparam logic [63:0] SNAN = 64'h7FF0_0000_0000_0001;
  localparam logic [63:0] NINF = 64'hFFF0_0000_0000_0000;
  localparam logic [63:0] FIVE = 64'h4014_0000_0000_0000;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         req_valid, req_ready, req_scalar, req_single, req_signaling;
  logic [1:0]   req_pred;
  logic [127:0] req_a, req_b;
  logic         exc_valid, exc_invalid, exc_trap;
  logic [0:0]   exc_lane;
  logic         res_valid, res_invalid, res_trapped;
  logic [127:0] res_mask;
  logic [1:0]   res_cc;

  int tests = 0;
  int fails = 0;
  int trap_lane_cur = -1;
  int lane_seen = 0;

  typedef struct {
    logic [127:0] mask;
    logic [1:0]   cc;
    logic         inv;
    logic         trp;
    int           nl;
    string        tag;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  vfc_compare i_vfc_compare (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_scalar(req_scalar), .req_pred(req_pred), .req_single(req_single),
    .req_signaling(req_signaling), .req_a(req_a), .req_b(req_b),
    .exc_valid(exc_valid), .exc_lane(exc_lane), .exc_invalid(exc_invalid),
    .exc_trap(exc_trap), .res_valid(res_valid), .res_mask(res_mask),
    .res_cc(res_cc), .res_invalid(res_invalid), .res_trapped(res_trapped)
  );

  function automatic logic is_nan(logic [63:0] v);
    return (v[62:52] == 11'h7FF) && (v[51:0] != 52'd0);
  endfunction

  function automatic logic is_snan(logic [63:0] v);
    return is_nan(v) && !v[51];
  endfunction

  // driver: predicts the result, pushes it, then issues the request
  task automatic run(input logic scl, input logic [1:0] pred, input logic sgl,
                     input logic sig, input logic [63:0] a0, input logic [63:0] a1,
                     input logic [63:0] b0, input logic [63:0] b1,
                     input int tl, input string tag);
    exp_t e;
    logic [63:0] av [2];
    logic [63:0] bv [2];
    int n, cnt;
    av[0] = a0; av[1] = a1; bv[0] = b0; bv[1] = b1;
    e.mask = '0; e.inv = 1'b0; e.trp = 1'b0; e.tag = tag; cnt = 0;
    n = (scl || sgl) ? 1 : 2;
    e.nl = n;
    if (scl) begin
      real ra, rb;
      ra = $bitstoreal(a0); rb = $bitstoreal(b0);
      e.inv = sig ? (is_nan(a0) || is_nan(b0)) : (is_snan(a0) || is_snan(b0));
      if (is_nan(a0) || is_nan(b0)) e.cc = 2'd3;
      else if (ra == rb)            e.cc = 2'd0;
      else if (ra < rb)             e.cc = 2'd1;
      else                          e.cc = 2'd2;
      if (tl == 0) e.trp = 1'b1;
    end else begin
      for (int i = 0; i < n; i++) begin
        real ra, rb;
        logic m;
        ra = $bitstoreal(av[i]); rb = $bitstoreal(bv[i]);
        if (is_nan(av[i]) || is_nan(bv[i])) m = 1'b0;
        else if (pred == 2'd1)              m = ra > rb;
        else if (pred == 2'd2)              m = ra >= rb;
        else                                m = ra == rb;
        if (m) begin
          e.mask[i*64 +: 64] = {64{1'b1}};
          cnt++;
        end
        if (is_snan(av[i]) || is_snan(bv[i])) e.inv = 1'b1;
        if (i == tl) begin
          e.trp = 1'b1;
          e.nl = i + 1;
          break;
        end
      end
      if (cnt == 0)             e.cc = 2'd3;
      else if (sgl || cnt == 2) e.cc = 2'd0;
      else                      e.cc = 2'd1;
    end
    sb.push_back(e);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_scalar = scl; req_pred = pred; req_single = sgl;
    req_signaling = sig; req_a = {a1, a0}; req_b = {b1, b0};
    trap_lane_cur = tl;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // trap responder (exception unit model)
  always @(negedge clk) begin
    exc_trap = exc_valid && (int'(exc_lane) == trap_lane_cur);
  end

  // monitor
  always @(negedge clk) begin
    if (rst_n && exc_valid) begin
      if (int'(exc_lane) != lane_seen) begin
        tests++; fails++;
        $display("FAIL R11 lane order: got %0d expected %0d", exc_lane, lane_seen);
      end
      lane_seen++;
    end
    if (rst_n && res_valid) begin
      exp_t e;
      tests++;
      if (sb.size() == 0) begin
        fails++;
        $display("FAIL R11 unexpected result: got cc=%0d expected none", res_cc);
      end else begin
        e = sb.pop_front();
        if (res_mask !== e.mask || res_cc !== e.cc || res_invalid !== e.inv ||
            res_trapped !== e.trp || lane_seen != e.nl) begin
          fails++;
          $display("FAIL %s: got mask=%h cc=%0d inv=%0d trp=%0d lanes=%0d expected mask=%h cc=%0d inv=%0d trp=%0d lanes=%0d",
                   e.tag, res_mask, res_cc, res_invalid, res_trapped, lane_seen,
                   e.mask, e.cc, e.inv, e.trp, e.nl);
        end
      end
      lane_seen = 0;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: got hung run expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_scalar = 1'b0; req_pred = 2'd0;
    req_single = 1'b0; req_signaling = 1'b0; req_a = '0; req_b = '0;
    exc_trap = 1'b0;
    repeat (3) @(negedge clk);
    tests++;
    if (res_valid !== 1'b0 || exc_valid !== 1'b0 || req_ready !== 1'b1 || res_mask !== '0) begin
      fails++;
      $display("FAIL R1 reset state: got valid=%0d exc=%0d ready=%0d expected 0 0 1",
               res_valid, exc_valid, req_ready);
    end
    rst_n = 1'b1;
    @(negedge clk);
    tests++;
    if (res_valid !== 1'b0 || req_ready !== 1'b1 || res_mask !== '0) begin
      fails++;
      $display("FAIL R1 after reset: got valid=%0d ready=%0d expected 0 1", res_valid, req_ready);
    end

    run(0, 2'd0, 0, 0, ONE, TWO, ONE, TWO, -1, "R2 R5 eq all match");
    run(0, 2'd0, 0, 0, ONE, TWO, ONE, ONE, -1, "R5 eq some match");
    run(0, 2'd0, 0, 0, PZ, QNAN, NZ, QNAN, -1, "R3 signed zero and qnan");
    run(0, 2'd1, 0, 0, TWO, NEG1, ONE, ONE, -1, "R4 greater");
    run(0, 2'd2, 0, 0, ONE, NEG1, ONE, NINF, -1, "R4 greater-or-equal");
    run(0, 2'd1, 0, 0, ONE, ONE, TWO, TWO, -1, "R5 none match");
    run(0, 2'd2, 0, 0, QNAN, ONE, ONE, NEG1, -1, "R3 R4 nan false");
    run(0, 2'd0, 1, 0, ONE, FIVE, ONE, TWO, -1, "R6 single match");
    run(0, 2'd0, 1, 0, TWO, ONE, ONE, ONE, -1, "R6 single miss");
    run(1, 2'd0, 0, 0, ONE, TWO, TWO, TWO, -1, "R7 scalar low");
    run(1, 2'd0, 0, 0, TWO, ONE, ONE, ONE, -1, "R7 scalar high");
    run(1, 2'd0, 0, 0, NZ, ONE, PZ, TWO, -1, "R7 scalar equal zeros");
    run(1, 2'd0, 0, 0, QNAN, ONE, ONE, ONE, -1, "R8 quiet qnan");
    run(1, 2'd0, 0, 1, QNAN, ONE, ONE, ONE, -1, "R8 signaling qnan");
    run(1, 2'd0, 0, 0, SNAN, ONE, ONE, ONE, -1, "R8 quiet snan");
    run(0, 2'd0, 0, 0, ONE, SNAN, ONE, ONE, -1, "R10 invalid in lane 1");
    run(0, 2'd0, 0, 0, ONE, ONE, ONE, ONE, 0, "R9 trap lane 0");
    run(0, 2'd1, 0, 0, TWO, SNAN, ONE, ONE, 1, "R9 R10 trap lane 1");
    run(0, 2'd0, 0, 0, SNAN, ONE, ONE, ONE, 0, "R9 trap stops before lane 1");

    while (sb.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule